// File: doc/BRIEF.md
# First-Level Fully Associative Translation Buffer

This block caches recent virtual-to-physical translations for a single requester, either the instruction side or the data side. A lookup presents a virtual address together with the current address space identifier (ASID) and virtual machine identifier (VMID). All entries are compared in the same cycle. One clock later the block returns a hit flag, the 40-bit physical address and the stored attribute bits. Each entry carries its own page size, so large and small mappings share the same storage. The context match uses the ASID, the VMID and a global flag, so a context switch does not require a flush.

When a lookup misses, the block stops accepting lookups. It raises a request to the second-level translation stage, carrying the missed address and context. It then waits for either a refill or an error answer. A refill is written into a free slot if one exists, and otherwise into the slot a rotating pointer selects. The requester then repeats its lookup. Three invalidation commands clear entries in a single cycle: clear everything, clear by ASID, or clear by VMID.

Top module: `tlb_l1_fa`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` is high, and `rsp_valid` and `miss_req_valid` are low.
- R2: A lookup accepted on a clock edge (`lk_valid` and `lk_ready` both high) produces `rsp_valid` high for the following cycle, together with `rsp_hit`, `rsp_pa` and `rsp_attr`. On a miss, `rsp_pa` and `rsp_attr` are zero.
- R3: An entry matches only if its VMID equals `lk_vmid` and, in addition, either its global flag is set or its ASID equals `lk_asid`.
- R4: The `fill_size` codes are 0 for 4 KiB, 1 for 16 KiB, 2 for 64 KiB, 3 for 2 MiB and 4 for 512 MiB. Virtual address bits at and above the page shift (12, 14, 16, 21 or 29) take part in the match. Physical address bits below the shift are copied from the virtual address, and the bits above it come from the stored frame.
- R5: After a miss, `lk_ready` is low from the next cycle on. `miss_req_valid` is high in the same cycles, and `miss_req_va`, `miss_req_asid` and `miss_req_vmid` hold the missed lookup's values until the miss is resolved.
- R6: While a miss is pending, `fill_valid` writes the translation. The new entry takes its virtual page and context from the missed lookup, and its frame, size, global flag and attributes from the fill inputs. `fill_err` resolves the miss without writing anything. In both cases `lk_ready` is high again on the next cycle.
- R7: A refill goes to the lowest-numbered invalid entry. When every entry is valid, it goes to a rotating victim pointer that starts at entry 0 and advances by one, wrapping after the last entry, on each replacement.
- R8: `inv_valid` with `inv_kind` 0 clears all entries. Kind 1 clears the non-global entries whose ASID equals `inv_asid`. Kind 2 clears the entries whose VMID equals `inv_vmid`. Kind 3 has no effect. The command takes effect on the edge where it is sampled.
- R9: If several valid entries match, the lowest-numbered entry supplies the address and attributes, and `rsp_multi_hit` is high with the response.
- R10: The default parameters give 48 entries: 48 distinct pages can be resident at once, and the 49th refill evicts one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Block can accept a lookup |
| lk_va | input | VA_W | Lookup virtual address |
| lk_asid | input | ASID_W | Current address space identifier |
| lk_vmid | input | VMID_W | Current virtual machine identifier |
| rsp_valid | output | 1 | Response for the lookup accepted one cycle earlier |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_pa | output | PA_W | Translated physical address |
| rsp_attr | output | ATTR_W | Attribute bits of the matching entry |
| rsp_multi_hit | output | 1 | More than one entry matched |
| miss_req_valid | output | 1 | Miss pending toward the second-level stage |
| miss_req_va | output | VA_W | Missed virtual address |
| miss_req_asid | output | ASID_W | Missed lookup's ASID |
| miss_req_vmid | output | VMID_W | Missed lookup's VMID |
| fill_valid | input | 1 | Refill answer |
| fill_err | input | 1 | Error answer; nothing is written |
| fill_pa | input | PA_W | Refill physical address (frame bits used) |
| fill_size | input | 3 | Refill page size code |
| fill_global | input | 1 | Refill global flag |
| fill_attr | input | ATTR_W | Refill attribute bits |
| inv_valid | input | 1 | Invalidation command |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 by VMID, 3 none |
| inv_asid | input | ASID_W | ASID for kind 1 |
| inv_vmid | input | VMID_W | VMID for kind 2 |

## Verification
A stale valid bit or a wrong stored context shows up on the very next lookup to that page. It appears as a hit where a miss was expected, or the reverse, one cycle after the request. A wrongly stored size or frame appears as corrupted physical address bits, either just above or just below the page shift, in that same response. A victim pointer that is off by one stays hidden until the buffer is full. The bench therefore fills all entries and checks which page is lost on the next two refills. A broken miss state machine shows up at once, as `lk_ready` or `miss_req_valid` staying wrong in the cycle after a miss or a refill.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int BASE_SHIFT = 12;

   typedef enum logic [2:0] {
      PG_4K   = 3'd0,
      PG_16K  = 3'd1,
      PG_64K  = 3'd2,
      PG_2M   = 3'd3,
      PG_512M = 3'd4
   } pg_size_e;

   typedef enum logic [1:0] {
      INV_ALL  = 2'd0,
      INV_ASID = 2'd1,
      INV_VMID = 2'd2,
      INV_NONE = 2'd3
   } inv_kind_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } walk_st_e;

   // Number of low address bits that pass straight through for a size code.
   function automatic int page_shift(input logic [2:0] sz);
      case (sz)
         PG_16K:  return 14;
         PG_64K:  return 16;
         PG_2M:   return 21;
         PG_512M: return 29;
         default: return BASE_SHIFT;
      endcase
   endfunction

endpackage

// File: rtl/tlb_entry_cmp.sv
module tlb_entry_cmp
   import tlb_pkg::*;
#(
   parameter int VA_W   = 48,
   parameter int PA_W   = 40,
   parameter int ASID_W = 16,
   parameter int VMID_W = 16
) (
   input  logic              valid_i,
   input  logic              glb_i,
   input  logic [2:0]        size_i,
   input  logic [ASID_W-1:0] asid_i,
   input  logic [VMID_W-1:0] vmid_i,
   input  logic [VA_W-BASE_SHIFT-1:0] vpn_i,
   input  logic [PA_W-BASE_SHIFT-1:0] ppn_i,
   input  logic [VA_W-1:0]   lk_va_i,
   input  logic [ASID_W-1:0] cur_asid_i,
   input  logic [VMID_W-1:0] cur_vmid_i,
   input  logic [1:0]        inv_kind_i,
   input  logic [ASID_W-1:0] inv_asid_i,
   input  logic [VMID_W-1:0] inv_vmid_i,
   output logic              hit_o,
   output logic [PA_W-1:0]   pa_o,
   output logic              kill_o
);

   localparam int VPN_W = VA_W - BASE_SHIFT;
   localparam int PPN_W = PA_W - BASE_SHIFT;

   int               shift;
   logic [VPN_W-1:0] cmp_msk;   // 1 where the bit belongs to the page number
   logic             ctx_ok;
   logic             vpn_ok;

   always_comb begin
      shift = page_shift(size_i);
      for (int j = 0; j < VPN_W; j++) begin
         cmp_msk[j] = ((j + BASE_SHIFT) >= shift);
      end
   end

   assign ctx_ok = (vmid_i == cur_vmid_i) && (glb_i || (asid_i == cur_asid_i));
   assign vpn_ok = &(~(vpn_i ^ lk_va_i[VA_W-1:BASE_SHIFT]) | ~cmp_msk);
   assign hit_o  = valid_i && ctx_ok && vpn_ok;

   always_comb begin
      pa_o[BASE_SHIFT-1:0] = lk_va_i[BASE_SHIFT-1:0];
      for (int j = 0; j < PPN_W; j++) begin
         pa_o[j+BASE_SHIFT] = cmp_msk[j] ? ppn_i[j] : lk_va_i[j+BASE_SHIFT];
      end
   end

   always_comb begin
      case (inv_kind_i)
         INV_ALL:  kill_o = 1'b1;
         INV_ASID: kill_o = !glb_i && (asid_i == inv_asid_i);
         INV_VMID: kill_o = (vmid_i == inv_vmid_i);
         default:  kill_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
   parameter int N = 48
) (
   input  logic [N-1:0] hit_i,
   output logic [N-1:0] grant_o,
   output logic         any_o,
   output logic         multi_o
);

   logic found;

   always_comb begin
      grant_o = '0;
      found   = 1'b0;
      for (int i = 0; i < N; i++) begin
         if (hit_i[i] && !found) begin
            grant_o[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   assign any_o   = |hit_i;
   assign multi_o = |(hit_i & ~grant_o);

endmodule

// File: rtl/tlb_victim_sel.sv
module tlb_victim_sel #(
   parameter int N = 48
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         valid_i,
   input  logic                 take_i,
   output logic [$clog2(N)-1:0] victim_o
);

   localparam int IDX_W = $clog2(N);

   logic [IDX_W-1:0] rr_q;
   logic [IDX_W-1:0] rr_nxt;
   logic [IDX_W-1:0] free_idx;
   logic             have_free;

   always_comb begin
      have_free = 1'b0;
      free_idx  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            have_free = 1'b1;
            free_idx  = IDX_W'(i);
         end
      end
   end

   if ((N & (N - 1)) == 0) begin : g_pow2
      assign rr_nxt = rr_q + 1'b1;
   end else begin : g_wrap
      assign rr_nxt = (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rr_q <= '0;
      end else if (take_i && !have_free) begin
         rr_q <= rr_nxt;
      end
   end

   assign victim_o = have_free ? free_idx : rr_q;

   AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !(&valid_i)) |-> !valid_i[victim_o]); // R7

   AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |-> (int'(victim_o) < N)); // R7

endmodule

// File: rtl/tlb_l1_fa.sv
module tlb_l1_fa
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 48,
   parameter int VA_W    = 48,
   parameter int PA_W    = 40,
   parameter int ASID_W  = 16,
   parameter int VMID_W  = 16,
   parameter int ATTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   output logic              lk_ready,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic [VMID_W-1:0] lk_vmid,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [PA_W-1:0]   rsp_pa,
   output logic [ATTR_W-1:0] rsp_attr,
   output logic              rsp_multi_hit,
   output logic              miss_req_valid,
   output logic [VA_W-1:0]   miss_req_va,
   output logic [ASID_W-1:0] miss_req_asid,
   output logic [VMID_W-1:0] miss_req_vmid,
   input  logic              fill_valid,
   input  logic              fill_err,
   input  logic [PA_W-1:0]   fill_pa,
   input  logic [2:0]        fill_size,
   input  logic              fill_global,
   input  logic [ATTR_W-1:0] fill_attr,
   input  logic              inv_valid,
   input  logic [1:0]        inv_kind,
   input  logic [ASID_W-1:0] inv_asid,
   input  logic [VMID_W-1:0] inv_vmid
);

   localparam int IDX_W = $clog2(ENTRIES);
   localparam int VPN_W = VA_W - BASE_SHIFT;
   localparam int PPN_W = PA_W - BASE_SHIFT;

   // Elaboration-time parameter checks
   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlb_l1_fa: ENTRIES must be at least 2");
   end
   if (PA_W <= 29) begin : g_bad_pa
      $error("tlb_l1_fa: PA_W must exceed the largest page shift");
   end
   if (VA_W < PA_W) begin : g_bad_va
      $error("tlb_l1_fa: VA_W must not be narrower than PA_W");
   end

   // Entry storage
   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] vld_d;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [PPN_W-1:0]   ppn_q  [ENTRIES];
   logic [2:0]         size_q [ENTRIES];
   logic               glb_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [VMID_W-1:0]  vmid_q [ENTRIES];
   logic [ATTR_W-1:0]  attr_q [ENTRIES];

   // Per-entry results
   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] kill_vec;
   logic [PA_W-1:0]    ent_pa [ENTRIES];

   logic [ENTRIES-1:0] grant;
   logic               any_hit;
   logic               multi_hit;
   logic [IDX_W-1:0]   victim;

   walk_st_e           st_q;
   logic [VA_W-1:0]    miss_va_q;
   logic [ASID_W-1:0]  miss_asid_q;
   logic [VMID_W-1:0]  miss_vmid_q;

   logic               lk_fire;
   logic               fill_take;
   logic               miss_done;

   logic [PA_W-1:0]    pa_sel;
   logic [ATTR_W-1:0]  attr_sel;

   logic               rsp_valid_q;
   logic               rsp_hit_q;
   logic [PA_W-1:0]    rsp_pa_q;
   logic [ATTR_W-1:0]  rsp_attr_q;
   logic               rsp_multi_q;

   logic               unused_fill_low;
   assign unused_fill_low = ^fill_pa[BASE_SHIFT-1:0];

   assign lk_ready  = (st_q == ST_IDLE);
   assign lk_fire   = lk_valid && lk_ready;
   assign miss_done = (st_q == ST_WAIT) && (fill_valid || fill_err);
   assign fill_take = (st_q == ST_WAIT) && fill_valid && !fill_err;

   // Parallel comparators, one per entry
   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      tlb_entry_cmp #(
         .VA_W   (VA_W),
         .PA_W   (PA_W),
         .ASID_W (ASID_W),
         .VMID_W (VMID_W)
      ) u_cmp (
         .valid_i    (vld_q[i]),
         .glb_i      (glb_q[i]),
         .size_i     (size_q[i]),
         .asid_i     (asid_q[i]),
         .vmid_i     (vmid_q[i]),
         .vpn_i      (vpn_q[i]),
         .ppn_i      (ppn_q[i]),
         .lk_va_i    (lk_va),
         .cur_asid_i (lk_asid),
         .cur_vmid_i (lk_vmid),
         .inv_kind_i (inv_kind),
         .inv_asid_i (inv_asid),
         .inv_vmid_i (inv_vmid),
         .hit_o      (hit_vec[i]),
         .pa_o       (ent_pa[i]),
         .kill_o     (kill_vec[i])
      );
   end

   tlb_prio_pick #(.N(ENTRIES)) u_pick (
      .hit_i   (hit_vec),
      .grant_o (grant),
      .any_o   (any_hit),
      .multi_o (multi_hit)
   );

   tlb_victim_sel #(.N(ENTRIES)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (vld_q),
      .take_i   (fill_take),
      .victim_o (victim)
   );

   // Result mux driven by the one-hot grant
   always_comb begin
      pa_sel   = '0;
      attr_sel = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (grant[i]) begin
            pa_sel   = pa_sel | ent_pa[i];
            attr_sel = attr_sel | attr_q[i];
         end
      end
   end

   // Valid bits: the refill is applied after any invalidation in the same cycle
   always_comb begin
      vld_d = vld_q;
      if (inv_valid) begin
         vld_d = vld_d & ~kill_vec;
      end
      for (int i = 0; i < ENTRIES; i++) begin
         if (fill_take && (victim == IDX_W'(i))) begin
            vld_d[i] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         vld_q <= vld_d;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_take) begin
         vpn_q[victim]  <= miss_va_q[VA_W-1:BASE_SHIFT];
         ppn_q[victim]  <= fill_pa[PA_W-1:BASE_SHIFT];
         size_q[victim] <= fill_size;
         glb_q[victim]  <= fill_global;
         asid_q[victim] <= miss_asid_q;
         vmid_q[victim] <= miss_vmid_q;
         attr_q[victim] <= fill_attr;
      end
   end

   // Miss state machine
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         miss_va_q   <= '0;
         miss_asid_q <= '0;
         miss_vmid_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (lk_fire && !any_hit) begin
                  st_q        <= ST_WAIT;
                  miss_va_q   <= lk_va;
                  miss_asid_q <= lk_asid;
                  miss_vmid_q <= lk_vmid;
               end
            end
            default: begin
               if (miss_done) begin
                  st_q <= ST_IDLE;
               end
            end
         endcase
      end
   end

   // Registered response
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_hit_q   <= 1'b0;
         rsp_pa_q    <= '0;
         rsp_attr_q  <= '0;
         rsp_multi_q <= 1'b0;
      end else begin
         rsp_valid_q <= lk_fire;
         rsp_hit_q   <= lk_fire && any_hit;
         rsp_pa_q    <= (lk_fire && any_hit) ? pa_sel : '0;
         rsp_attr_q  <= (lk_fire && any_hit) ? attr_sel : '0;
         rsp_multi_q <= lk_fire && multi_hit;
      end
   end

   assign rsp_valid      = rsp_valid_q;
   assign rsp_hit        = rsp_hit_q;
   assign rsp_pa         = rsp_pa_q;
   assign rsp_attr       = rsp_attr_q;
   assign rsp_multi_hit  = rsp_multi_q;
   assign miss_req_valid = (st_q == ST_WAIT);
   assign miss_req_va    = miss_va_q;
   assign miss_req_asid  = miss_asid_q;
   assign miss_req_vmid  = miss_vmid_q;

   AST_LOOKUP_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_ready) |=> rsp_valid); // R2

   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && rsp_attr == '0)); // R2

   AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> (miss_req_valid && !lk_ready)); // R5

   AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req_valid && !fill_valid && !fill_err) |=>
         (miss_req_valid && $stable(miss_req_va) && $stable(miss_req_asid))); // R5

   AST_FILL_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_req_valid && (fill_valid || fill_err)) |=> (lk_ready && !miss_req_valid)); // R6

   AST_MULTI_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi_hit |-> (rsp_valid && rsp_hit)); // R9

endmodule

// File: tb/tlb_l1_fa_tb.sv
`timescale 1ns/1ps
module tlb_l1_fa_tb;

   localparam int N = 48;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic        lk_ready;
   logic [47:0] lk_va = '0;
   logic [15:0] lk_asid = '0;
   logic [15:0] lk_vmid = '0;
   logic        rsp_valid;
   logic        rsp_hit;
   logic [39:0] rsp_pa;
   logic [7:0]  rsp_attr;
   logic        rsp_multi_hit;
   logic        miss_req_valid;
   logic [47:0] miss_req_va;
   logic [15:0] miss_req_asid;
   logic [15:0] miss_req_vmid;
   logic        fill_valid = 1'b0;
   logic        fill_err = 1'b0;
   logic [39:0] fill_pa = '0;
   logic [2:0]  fill_size = '0;
   logic        fill_global = 1'b0;
   logic [7:0]  fill_attr = '0;
   logic        inv_valid = 1'b0;
   logic [1:0]  inv_kind = 2'd3;
   logic [15:0] inv_asid = '0;
   logic [15:0] inv_vmid = '0;

   always #2.5 clk = ~clk;

   tlb_l1_fa u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va),
      .lk_asid(lk_asid), .lk_vmid(lk_vmid),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pa(rsp_pa),
      .rsp_attr(rsp_attr), .rsp_multi_hit(rsp_multi_hit),
      .miss_req_valid(miss_req_valid), .miss_req_va(miss_req_va),
      .miss_req_asid(miss_req_asid), .miss_req_vmid(miss_req_vmid),
      .fill_valid(fill_valid), .fill_err(fill_err), .fill_pa(fill_pa),
      .fill_size(fill_size), .fill_global(fill_global), .fill_attr(fill_attr),
      .inv_valid(inv_valid), .inv_kind(inv_kind), .inv_asid(inv_asid),
      .inv_vmid(inv_vmid)
   );

   typedef struct {
      logic        hit;
      logic [39:0] pa;
      logic [7:0]  attr;
      logic        multi;
      string       tag;
   } exp_t;

   exp_t sbq[$];
   exp_t mon_e;
   int   nvec = 0;
   int   nfail = 0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: compares every response against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         if (sbq.size() == 0) begin
            chk(1'b0, "R2 response without request", 64'(rsp_valid), 64'd0);
         end else begin
            mon_e = sbq.pop_front();
            chk(rsp_hit == mon_e.hit, {mon_e.tag, " hit"}, 64'(rsp_hit), 64'(mon_e.hit));
            chk(rsp_pa == mon_e.pa, {mon_e.tag, " pa"}, 64'(rsp_pa), 64'(mon_e.pa));
            chk(rsp_attr == mon_e.attr, {mon_e.tag, " attr"}, 64'(rsp_attr), 64'(mon_e.attr));
            chk(rsp_multi_hit == mon_e.multi, {mon_e.tag, " multi"}, 64'(rsp_multi_hit), 64'(mon_e.multi));
         end
      end
   end

   function automatic logic [39:0] exp_pa(input logic [39:0] pa, input logic [47:0] va, input int sh);
      logic [39:0] m;
      m = (40'd1 << sh) - 40'd1;
      return (pa & ~m) | (va[39:0] & m);
   endfunction

   // Driver: pushes the expectation and presents one lookup
   task automatic lookup(input logic [47:0] va, input logic [15:0] asid, input logic [15:0] vmid,
                         input logic ehit, input logic [39:0] epa, input logic [7:0] eattr,
                         input logic emulti, input string tag);
      exp_t e;
      e.hit = ehit; e.pa = ehit ? epa : 40'd0; e.attr = ehit ? eattr : 8'd0;
      e.multi = emulti; e.tag = tag;
      sbq.push_back(e);
      lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_vmid = vmid;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic miss_open(input logic [47:0] va, input logic [15:0] asid, input logic [15:0] vmid,
                            input string tag);
      lookup(va, asid, vmid, 1'b0, 40'd0, 8'd0, 1'b0, tag);
      chk(lk_ready == 1'b0, "R5 ready low after miss", 64'(lk_ready), 64'd0);
      chk(miss_req_valid == 1'b1, "R5 miss request raised", 64'(miss_req_valid), 64'd1);
      chk(miss_req_va == va, "R5 miss va", 64'(miss_req_va), 64'(va));
      chk(miss_req_asid == asid && miss_req_vmid == vmid, "R5 miss context",
          {32'(miss_req_asid), 32'(miss_req_vmid)}, {32'(asid), 32'(vmid)});
   endtask

   task automatic refill(input logic [39:0] pa, input logic [2:0] sz, input logic glb,
                         input logic [7:0] attr);
      fill_valid = 1'b1; fill_pa = pa; fill_size = sz; fill_global = glb; fill_attr = attr;
      @(negedge clk);
      fill_valid = 1'b0;
      chk(lk_ready == 1'b1 && miss_req_valid == 1'b0, "R6 ready after refill",
          64'({lk_ready, miss_req_valid}), 64'b10);
   endtask

   task automatic refuse;
      fill_err = 1'b1;
      @(negedge clk);
      fill_err = 1'b0;
      chk(lk_ready == 1'b1 && miss_req_valid == 1'b0, "R6 ready after error",
          64'({lk_ready, miss_req_valid}), 64'b10);
   endtask

   task automatic miss_fill(input logic [47:0] va, input logic [15:0] asid, input logic [15:0] vmid,
                            input logic [39:0] pa, input logic [2:0] sz, input logic glb,
                            input logic [7:0] attr, input string tag);
      miss_open(va, asid, vmid, tag);
      refill(pa, sz, glb, attr);
   endtask

   task automatic miss_drop(input logic [47:0] va, input logic [15:0] asid, input logic [15:0] vmid,
                            input string tag);
      miss_open(va, asid, vmid, tag);
      refuse();
   endtask

   task automatic inval(input logic [1:0] kind, input logic [15:0] asid, input logic [15:0] vmid);
      inv_valid = 1'b1; inv_kind = kind; inv_asid = asid; inv_vmid = vmid;
      @(negedge clk);
      inv_valid = 1'b0; inv_kind = 2'd3;
   endtask

   task automatic summary;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog R2: actual run still going, expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(lk_ready == 1'b1, "R1 ready after reset", 64'(lk_ready), 64'd1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
      chk(miss_req_valid == 1'b0, "R1 no miss after reset", 64'(miss_req_valid), 64'd0);

      // R1/R2/R6 4 KiB page: empty buffer misses, refill, then hit
      miss_fill(48'h0000_1234_5000, 16'd5, 16'd1, 40'h12_3456_7000, 3'd0, 1'b0, 8'h5A, "R1 empty miss");
      lookup(48'h0000_1234_5ABC, 16'd5, 16'd1, 1'b1, 40'h12_3456_7ABC, 8'h5A, 1'b0, "R2 4K hit");

      // R3 ASID mismatch on non-global entry; R6 error writes nothing
      miss_drop(48'h0000_1234_5000, 16'd6, 16'd1, "R3 asid mismatch");
      miss_drop(48'h0000_1234_5000, 16'd6, 16'd1, "R6 error left no entry");
      // R3 VMID mismatch
      miss_drop(48'h0000_1234_5000, 16'd5, 16'd2, "R3 vmid mismatch");

      // R3 global 64 KiB page: any ASID within the VMID
      miss_fill(48'h0000_7700_0000, 16'd7, 16'd1, 40'h0A_BCDE_F123, 3'd2, 1'b1, 8'h33, "R3 global miss");
      lookup(48'h0000_7700_FEDC, 16'd9, 16'd1, 1'b1, 40'h0A_BCDE_FEDC, 8'h33, 1'b0, "R3 global other asid");
      miss_drop(48'h0000_7700_FEDC, 16'd9, 16'd3, "R3 global other vmid");

      // R4 page sizes: low frame bits must be replaced by VA bits
      miss_fill(48'h0000_2000_4000, 16'd5, 16'd1, 40'h55_0000_3000, 3'd1, 1'b0, 8'h41, "R4 16K miss");
      lookup(48'h0000_2000_4123, 16'd5, 16'd1, 1'b1,
             exp_pa(40'h55_0000_3000, 48'h0000_2000_4123, 14), 8'h41, 1'b0, "R4 16K hit");
      miss_drop(48'h0000_2000_8000, 16'd5, 16'd1, "R4 16K next page");
      miss_fill(48'h0000_4020_0000, 16'd5, 16'd1, 40'h66_001F_F000, 3'd3, 1'b0, 8'h42, "R4 2M miss");
      lookup(48'h0000_4020_0100, 16'd5, 16'd1, 1'b1,
             exp_pa(40'h66_001F_F000, 48'h0000_4020_0100, 21), 8'h42, 1'b0, "R4 2M hit");
      miss_fill(48'h0001_2000_0000, 16'd5, 16'd1, 40'h80_1234_5000, 3'd4, 1'b0, 8'h43, "R4 512M miss");
      lookup(48'h0001_3ABC_DEF0, 16'd5, 16'd1, 1'b1,
             exp_pa(40'h80_1234_5000, 48'h0001_3ABC_DEF0, 29), 8'h43, 1'b0, "R4 512M hit");

      // R8 invalidate by ASID keeps the global entry
      inval(2'd1, 16'd5, 16'd0);
      miss_drop(48'h0000_1234_5000, 16'd5, 16'd1, "R8 asid invalidated");
      lookup(48'h0000_7700_0010, 16'd2, 16'd1, 1'b1, 40'h0A_BCDE_0010, 8'h33, 1'b0, "R8 global kept");
      // R8 kind 3 does nothing
      inval(2'd3, 16'd0, 16'd1);
      lookup(48'h0000_7700_0020, 16'd2, 16'd1, 1'b1, 40'h0A_BCDE_0020, 8'h33, 1'b0, "R8 kind3 no effect");
      // R8 invalidate by VMID removes global entries too
      inval(2'd2, 16'd0, 16'd1);
      miss_drop(48'h0000_7700_0020, 16'd2, 16'd1, "R8 vmid invalidated");

      // R9 overlapping pages: entry 0 (4K) wins over entry 1 (2M)
      inval(2'd0, 16'd0, 16'd0);
      miss_fill(48'h0000_0060_1000, 16'd2, 16'd4, 40'h01_0000_1000, 3'd0, 1'b0, 8'h11, "R7 first free slot");
      miss_fill(48'h0000_0060_5000, 16'd2, 16'd4, 40'h02_0000_0000, 3'd3, 1'b0, 8'h22, "R7 second free slot");
      lookup(48'h0000_0060_10AB, 16'd2, 16'd4, 1'b1, 40'h01_0000_10AB, 8'h11, 1'b1, "R9 lowest index wins");
      lookup(48'h0000_0060_5010, 16'd2, 16'd4, 1'b1, 40'h02_0000_5010, 8'h22, 1'b0, "R9 single match");

      // R8 invalidate all
      inval(2'd0, 16'd0, 16'd0);
      miss_drop(48'h0000_0060_5010, 16'd2, 16'd4, "R8 all invalidated");

      // R7/R10 fill every slot, then replacement walks from entry 0
      for (int k = 0; k < N; k++) begin
         miss_fill(48'h0100_0000_0000 + (48'(k) << 12), 16'd1, 16'd1,
                   40'h10_0000_0000 + (40'(k) << 12), 3'd0, 1'b0, 8'(k), "R10 fill slot");
      end
      lookup(48'h0100_0000_0000 + (48'(N - 1) << 12), 16'd1, 16'd1, 1'b1,
             40'h10_0000_0000 + (40'(N - 1) << 12), 8'(N - 1), 1'b0, "R10 last slot resident");
      lookup(48'h0100_0000_0000, 16'd1, 16'd1, 1'b1, 40'h10_0000_0000, 8'd0, 1'b0, "R10 first slot resident");
      miss_fill(48'h0100_0000_0000 + (48'(N) << 12), 16'd1, 16'd1,
                40'h10_0000_0000 + (40'(N) << 12), 3'd0, 1'b0, 8'hF0, "R7 full refill");
      miss_drop(48'h0100_0000_0000, 16'd1, 16'd1, "R7 entry 0 replaced");
      lookup(48'h0100_0000_1000, 16'd1, 16'd1, 1'b1, 40'h10_0000_1000, 8'd1, 1'b0, "R7 entry 1 kept");
      lookup(48'h0100_0000_0000 + (48'(N) << 12), 16'd1, 16'd1, 1'b1,
             40'h10_0000_0000 + (40'(N) << 12), 8'hF0, 1'b0, "R7 new page resident");
      miss_fill(48'h0100_0000_0000 + (48'(N + 1) << 12), 16'd1, 16'd1,
                40'h10_0000_0000 + (40'(N + 1) << 12), 3'd0, 1'b0, 8'hF1, "R7 second refill");
      miss_drop(48'h0100_0000_1000, 16'd1, 16'd1, "R7 entry 1 replaced");
      lookup(48'h0100_0000_2000, 16'd1, 16'd1, 1'b1, 40'h10_0000_2000, 8'd2, 1'b0, "R7 entry 2 kept");

      repeat (3) @(negedge clk);
      chk(sbq.size() == 0, "R2 every lookup answered", 64'(sbq.size()), 64'd0);
      summary();
      $finish;
   end

endmodule